// File: doc/BRIEF.md
# Weighted Two-Queue Transmit Packet Arbiter

This block decides, one packet at a time, whether a transmitter takes its next packet from a high-priority queue or a low-priority queue. Each queue is turned on by a start pulse and off by a stop pulse. It turns itself off when it has no packet left. Only a running queue that has a packet available and no pending stop can win a grant. A grant is held until the packet engine pulses `pktDone`. The arbiter then spends one idle cycle before it decides again.

A 3-bit weight code sets how many high packets are sent before one low packet is due, when both queues compete. The codes 0 to 6 map to 1, 2, 4, 6, 8, 10 and 12 high packets per low packet. Code 7 gives the high queue strict priority. Each queue shows a running-status bit. It also gives a one-cycle end-of-queue pulse when a stop completes or when the queue runs dry.

Top module: `txarb_weighted`

## Requirements
- R1: After reset, both grants, both running bits and both end-of-queue pulses are 0.
- R2: A start pulse sets that queue's running bit at the next clock edge. A grant is only ever given to a running queue.
- R3: When both queues are eligible and the weight code is 0 to 6, the arbiter grants W high packets and then one low packet, and repeats. W is 1 for code 0 and twice the code value otherwise. After a low grant, the high count starts again from zero.
- R4: With weight code 7 (all ones), the high queue wins every decision in which it is eligible.
- R5: Whenever the high queue has no packet available, the count of high packets served is cleared. The next high packets start a fresh weight window.
- R6: When only one queue is eligible, that queue is granted, whatever the count.
- R7: A grant is held until `pktDone`. On the edge that samples `pktDone`, the grant drops. The next grant can appear one edge later.
- R8: A stop to the granted queue waits for `pktDone`. On that edge the grant drops, the running bit clears and the end-of-queue pulse is high for one cycle. The stopped queue gets no further grant.
- R9: A stop to a running queue that is not granted is latched on the first edge. On the second edge it clears the running bit and raises end-of-queue for one cycle.
- R10: A start to a queue cancels that queue's pending stop. The queue keeps running and raises no end-of-queue. A start and a stop in the same cycle act as a start.
- R11: A running queue that is not granted and has no packet available clears its running bit and raises end-of-queue for one cycle. This happens on the edge after the condition appears.
- R12: A stop to a queue that is not running has no effect. No end-of-queue is raised, and a later start is granted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hiAvail | input | 1 | High queue has a packet ready |
| loAvail | input | 1 | Low queue has a packet ready |
| pktDone | input | 1 | Current granted packet has finished |
| weightCode | input | WCODE_W | High-per-low weight code; all ones gives strict priority |
| startHi | input | 1 | Start pulse, high queue |
| startLo | input | 1 | Start pulse, low queue |
| stopHi | input | 1 | Stop pulse, high queue |
| stopLo | input | 1 | Stop pulse, low queue |
| grantHi | output | 1 | High queue holds the grant |
| grantLo | output | 1 | Low queue holds the grant |
| runHi | output | 1 | High queue running status |
| runLo | output | 1 | Low queue running status |
| eoqHi | output | 1 | One-cycle end-of-queue pulse, high queue |
| eoqLo | output | 1 | One-cycle end-of-queue pulse, low queue |

## Verification
The bench runs full weight windows for several codes and checks the exact order of grants. A wrong weight mapping, or a count that is not reloaded after a low grant, shifts where the low packet lands. A high-only run that goes past the weight, followed by an empty high queue, separates a design that clears the count on empty from one that carries the old count into the next window. With a count carried over, a low packet would come first. Held grants are used to check that a stop takes effect at the frame end rather than cutting the frame short, and that a stop to an ungranted queue completes without a grant. They also check that a start cancels a pending stop, that a stop to an idle queue raises no spurious end-of-queue, and that a queue running dry drops its running bit on the expected edge.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_HI   = 2'd1,
    GNT_LO   = 2'd2
  } grant_e;

  // strobes issued by the control to the count datapath
  typedef struct packed {
    logic takeHi;
    logic takeLo;
  } arb_stb_t;
endpackage

// File: rtl/txarb_qstate.sv
module txarb_qstate (
  input  logic clk,
  input  logic rstN,
  input  logic startCmd,
  input  logic stopCmd,
  input  logic avail,
  input  logic granted,
  input  logic done,
  output logic run,
  output logic stopPend,
  output logic eoq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      run      <= 1'b0;
      stopPend <= 1'b0;
      eoq      <= 1'b0;
    end else begin
      eoq <= 1'b0;
      if (startCmd) begin
        run      <= 1'b1;
        stopPend <= 1'b0;
      end else if (run) begin
        if (stopPend && (!granted || done)) begin
          run      <= 1'b0;
          stopPend <= 1'b0;
          eoq      <= 1'b1;
        end else if (!stopPend && !granted && !avail) begin
          run <= 1'b0;
          eoq <= 1'b1;
        end else if (stopCmd) begin
          stopPend <= 1'b1;
        end
      end
    end
  end

  // R8 / R11: the running bit never drops without an end-of-queue pulse
  a_r8_fall_has_eoq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run) |-> eoq);

  // R12: an idle queue that is not started cannot raise end-of-queue
  a_r12_idle_no_eoq: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !startCmd) |=> !eoq);
endmodule

// File: rtl/txarb_credit.sv
module txarb_credit
  import txarb_pkg::*;
#(
  parameter int WCODE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WCODE_W-1:0] weightCode,
  input  logic               hiAvail,
  input  arb_stb_t           stb,
  output logic               loDue
);
  localparam int CNT_W = WCODE_W + 1;
  localparam logic [WCODE_W-1:0] STRICT_CODE = '1;

  logic [CNT_W-1:0] hiServed;
  logic [CNT_W-1:0] weightVal;

  always_comb begin
    if (weightCode == '0) weightVal = CNT_W'(1);
    else                  weightVal = {weightCode, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiServed <= '0;
    end else if (stb.takeLo || !hiAvail) begin
      hiServed <= '0;
    end else if (stb.takeHi && (hiServed != '1)) begin
      hiServed <= hiServed + CNT_W'(1);
    end
  end

  assign loDue = (weightCode != STRICT_CODE) && (hiServed >= weightVal);

  // R3: both take strobes are never issued together
  a_r3_single_take: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.takeHi && stb.takeLo));
endmodule

// File: rtl/txarb_ctrl.sv
module txarb_ctrl
  import txarb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     eligHi,
  input  logic     eligLo,
  input  logic     loDue,
  input  logic     pktDone,
  output grant_e   gnt,
  output arb_stb_t stb
);
  grant_e nextGnt;

  always_comb begin
    stb     = '0;
    nextGnt = gnt;
    if (gnt == GNT_NONE) begin
      if (eligHi && (!eligLo || !loDue)) begin
        stb.takeHi = 1'b1;
        nextGnt    = GNT_HI;
      end else if (eligLo) begin
        stb.takeLo = 1'b1;
        nextGnt    = GNT_LO;
      end
    end else if (pktDone) begin
      nextGnt = GNT_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) gnt <= GNT_NONE;
    else       gnt <= nextGnt;
  end

  // R7: a grant stays put until the packet finishes
  a_r7_grant_held: assert property (@(posedge clk) disable iff (!rstN)
    (gnt != GNT_NONE && !pktDone) |=> $stable(gnt));
endmodule

// File: rtl/txarb_weighted.sv
module txarb_weighted
  import txarb_pkg::*;
#(
  parameter int WCODE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hiAvail,
  input  logic               loAvail,
  input  logic               pktDone,
  input  logic [WCODE_W-1:0] weightCode,
  input  logic               startHi,
  input  logic               startLo,
  input  logic               stopHi,
  input  logic               stopLo,
  output logic               grantHi,
  output logic               grantLo,
  output logic               runHi,
  output logic               runLo,
  output logic               eoqHi,
  output logic               eoqLo
);
  localparam int NQ = 2;

  grant_e   gnt;
  arb_stb_t stb;
  logic     loDue;
  logic [NQ-1:0] startV, stopV, availV, grantV, runV, pendV, eoqV, eligV;

  assign startV = {startLo, startHi};
  assign stopV  = {stopLo, stopHi};
  assign availV = {loAvail, hiAvail};
  assign grantV = {gnt == GNT_LO, gnt == GNT_HI};

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    txarb_qstate u_qstate (
      .clk      (clk),
      .rstN     (rstN),
      .startCmd (startV[q]),
      .stopCmd  (stopV[q]),
      .avail    (availV[q]),
      .granted  (grantV[q]),
      .done     (grantV[q] & pktDone),
      .run      (runV[q]),
      .stopPend (pendV[q]),
      .eoq      (eoqV[q])
    );
    assign eligV[q] = runV[q] & availV[q] & ~pendV[q];
  end

  txarb_credit #(.WCODE_W(WCODE_W)) u_credit (
    .clk        (clk),
    .rstN       (rstN),
    .weightCode (weightCode),
    .hiAvail    (hiAvail),
    .stb        (stb),
    .loDue      (loDue)
  );

  txarb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .eligHi  (eligV[0]),
    .eligLo  (eligV[1]),
    .loDue   (loDue),
    .pktDone (pktDone),
    .gnt     (gnt),
    .stb     (stb)
  );

  assign grantHi = grantV[0];
  assign grantLo = grantV[1];
  assign runHi   = runV[0];
  assign runLo   = runV[1];
  assign eoqHi   = eoqV[0];
  assign eoqLo   = eoqV[1];

  // R2: grants only go to running queues
  a_r2_hi_grant_running: assert property (@(posedge clk) disable iff (!rstN)
    grantHi |-> runHi);
  a_r2_lo_grant_running: assert property (@(posedge clk) disable iff (!rstN)
    grantLo |-> runLo);

  // R4: strict code hands an idle decision to an eligible high queue
  a_r4_strict_high: assert property (@(posedge clk) disable iff (!rstN)
    (!grantHi && !grantLo && eligV[0] && weightCode == '1) |=> grantHi);
endmodule

// File: tb/txarb_weighted_bench.sv
module txarb_weighted_bench;
  logic clk = 1'b0;
  logic rstN;
  logic hiAvail, loAvail, manDone, autoDone, autoReg, pktDone;
  logic [2:0] weightCode;
  logic startHi, startLo, stopHi, stopLo;
  logic grantHi, grantLo, runHi, runLo, eoqHi, eoqLo;

  int  nChk = 0;
  int  nFail = 0;
  bit  sbOn = 1'b0;
  bit  prevG = 1'b0;
  bit    sbExp[$];
  string sbReq[$];

  always #10 clk = ~clk;

  assign pktDone = autoDone ? autoReg : manDone;

  txarb_weighted u_txarb_weighted (
    .clk(clk), .rstN(rstN), .hiAvail(hiAvail), .loAvail(loAvail),
    .pktDone(pktDone), .weightCode(weightCode),
    .startHi(startHi), .startLo(startLo), .stopHi(stopHi), .stopLo(stopLo),
    .grantHi(grantHi), .grantLo(grantLo), .runHi(runHi), .runLo(runLo),
    .eoqHi(eoqHi), .eoqLo(eoqLo)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input bit isHi, input string req);
    sbExp.push_back(isHi);
    sbReq.push_back(req);
  endtask

  task automatic drain();
    while (sbExp.size() != 0) @(posedge clk);
    tick();
  endtask

  function automatic int weightOf(input int code);
    return (code == 0) ? 1 : 2 * code;
  endfunction

  // responder: finish each granted packet one cycle after it appears
  always @(negedge clk) autoReg <= autoDone && (grantHi || grantLo);

  // scoreboard monitor: compare each new grant against the expected queue
  always @(negedge clk) begin
    bit g;
    g = grantHi || grantLo;
    if (sbOn && g && !prevG) begin
      if (grantHi && grantLo) begin
        nChk++; nFail++;
        $display("FAIL R3 actual=both grants expected=one");
      end else if (sbExp.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL R3 actual=unexpected grant hi=%0d expected=none", grantHi);
      end else begin
        string r;
        bit e;
        e = sbExp.pop_front();
        r = sbReq.pop_front();
        chk(r, int'(grantHi), int'(e));
      end
    end
    prevG = g;
  end

  // both queues compete under a weight code 0..6 (R3)
  task automatic sbBoth(input int code, input int rounds);
    int w;
    w = weightOf(code);
    weightCode = 3'(code);
    for (int r = 0; r < rounds; r++) begin
      for (int i = 0; i < w; i++) push(1'b1, "R3");
      push(1'b0, "R3");
    end
    hiAvail = 1'b1; loAvail = 1'b1;
    startHi = 1'b1; startLo = 1'b1;
    tick();
    startHi = 1'b0; startLo = 1'b0;
    chk("R2", int'(runHi && runLo), 1);
    drain();
    hiAvail = 1'b0; loAvail = 1'b0;
    repeat (3) tick();
    chk("R11", int'(runHi || runLo), 0);
  endtask

  initial begin
    rstN = 1'b0; hiAvail = 1'b0; loAvail = 1'b0; manDone = 1'b0; autoDone = 1'b1;
    weightCode = 3'd0; startHi = 1'b0; startLo = 1'b0; stopHi = 1'b0; stopLo = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1", int'(grantHi || grantLo), 0);
    chk("R1", int'(runHi || runLo), 0);
    chk("R1", int'(eoqHi || eoqLo), 0);

    sbOn = 1'b1;
    sbBoth(0, 3);
    sbBoth(1, 2);
    sbBoth(3, 2);
    sbBoth(6, 2);

    // R4: strict priority, then the low queue served alone (R6)
    weightCode = 3'd7;
    for (int i = 0; i < 6; i++) push(1'b1, "R4");
    hiAvail = 1'b1; loAvail = 1'b1; startHi = 1'b1; startLo = 1'b1;
    tick();
    startHi = 1'b0; startLo = 1'b0;
    drain();
    hiAvail = 1'b0;
    for (int i = 0; i < 3; i++) push(1'b0, "R6");
    drain();
    loAvail = 1'b0;
    repeat (3) tick();

    // R6 high alone beyond the weight, then R5 fresh window after empty
    weightCode = 3'd2;
    for (int i = 0; i < 5; i++) push(1'b1, "R6");
    hiAvail = 1'b1; startHi = 1'b1;
    tick();
    startHi = 1'b0;
    drain();
    hiAvail = 1'b0;
    repeat (3) tick();
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 4; i++) push(1'b1, "R5");
      push(1'b0, "R5");
    end
    hiAvail = 1'b1; loAvail = 1'b1; startHi = 1'b1; startLo = 1'b1;
    tick();
    startHi = 1'b0; startLo = 1'b0;
    drain();
    hiAvail = 1'b0; loAvail = 1'b0;
    repeat (3) tick();
    chk("R3", sbExp.size(), 0);

    // manual frame-end control
    sbOn = 1'b0; autoDone = 1'b0;
    tick();
    loAvail = 1'b1; startLo = 1'b1;
    tick();
    startLo = 1'b0;
    chk("R2", int'(runLo), 1);
    tick();
    chk("R6", int'(grantLo), 1);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R7", int'(grantLo), 1);
    end
    manDone = 1'b1;
    tick();
    manDone = 1'b0;
    chk("R7", int'(grantLo), 0);
    tick();
    chk("R7", int'(grantLo), 1);

    // R9: stop to a running, ungranted high queue
    hiAvail = 1'b1; startHi = 1'b1;
    tick();
    startHi = 1'b0;
    chk("R9", int'(runHi), 1);
    stopHi = 1'b1;
    tick();
    stopHi = 1'b0;
    chk("R9", int'(runHi), 1);
    chk("R9", int'(eoqHi), 0);
    tick();
    chk("R9", int'(runHi), 0);
    chk("R9", int'(eoqHi), 1);
    tick();
    chk("R9", int'(eoqHi), 0);
    chk("R7", int'(grantLo), 1);
    hiAvail = 1'b0;

    // R12: stop to a stopped queue
    stopHi = 1'b1;
    tick();
    stopHi = 1'b0;
    chk("R12", int'(eoqHi), 0);
    tick();
    chk("R12", int'(eoqHi || runHi), 0);

    // R10: start cancels a pending stop on the granted low queue
    stopLo = 1'b1;
    tick();
    stopLo = 1'b0; startLo = 1'b1;
    tick();
    startLo = 1'b0; manDone = 1'b1;
    tick();
    manDone = 1'b0;
    chk("R10", int'(grantLo), 0);
    chk("R10", int'(runLo), 1);
    chk("R10", int'(eoqLo), 0);
    tick();
    chk("R10", int'(grantLo), 1);

    // R8: stop waits for frame end
    stopLo = 1'b1;
    tick();
    stopLo = 1'b0;
    tick(); tick();
    chk("R8", int'(grantLo && runLo), 1);
    chk("R8", int'(eoqLo), 0);
    manDone = 1'b1;
    tick();
    manDone = 1'b0;
    chk("R8", int'(grantLo), 0);
    chk("R8", int'(runLo), 0);
    chk("R8", int'(eoqLo), 1);
    tick();
    chk("R8", int'(eoqLo || grantLo), 0);

    // R12: restart after stop is granted normally
    startLo = 1'b1;
    tick();
    startLo = 1'b0;
    tick();
    chk("R12", int'(grantLo), 1);

    // R11: running dry after the last packet
    loAvail = 1'b0; manDone = 1'b1;
    tick();
    manDone = 1'b0;
    chk("R11", int'(runLo), 1);
    chk("R11", int'(eoqLo || grantLo), 0);
    tick();
    chk("R11", int'(runLo), 0);
    chk("R11", int'(eoqLo), 1);
    tick();
    chk("R11", int'(eoqLo), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R7 actual=watchdog expired expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule